// File: doc/BRIEF.md
# Bit-Serial Circulating Net Accumulator

This block sums a stream of serial products for one neuron. Each product arrives one bit per clock, least significant bit first, as a two's-complement word of P = 2N+2 bits, where N is the multiplier operand width. The running sum is held in a circular shift chain that is exactly P bits long, so it circulates in step with the multiplier period. One full adder with a single carry flip-flop combines three bits each cycle: the incoming product bit, the chain bit that has come back around to the adder, and the carry saved from the previous cycle. The sum bit re-enters the chain at the next edge.

A clear pulse zeroes the chain and starts a new neuron's sum, with the first product bit expected in the cycle after the clear. Once per period, when the chain's least significant bit is back at the adder, a fixed NET_W-bit window of the chain is presented as the net value for the activation lookup, and a one-cycle valid flag marks it. A small controller tracks this with three named states. ST_IDLE is entered at reset and accumulates nothing. ST_FILL is entered on clear and covers the first word. ST_ACC follows and raises valid at every word boundary. The transitions are ST_IDLE→ST_FILL on clear, ST_FILL→ST_ACC at the last bit of the first word, and any state→ST_FILL on clear. Otherwise every state holds.

Top module: `sacc_accum`

## Requirements
- R1: After reset, `net_vld` is 0 and `net` is 0.
- R2: A cycle with `clr` high zeroes the whole chain, restarts the bit phase at 0 and ignores `in_bit` in that cycle, so any partial sum in progress is discarded.
- R3: After a clear, the P-bit words on `in_bit` (LSB first, one bit per cycle, back to back) are summed modulo 2^P as two's-complement values.
- R4: The carry is forced to 0 at bit 0 of every word, so a carry out of one word's MSB never reaches the next word's LSB (for example, -1 + -1 + 0 gives -2).
- R5: `net` equals bits [2N-NET_W-2+NET_W-1 : 2N-NET_W-2] of the P-bit sum, which is bits [29:20] for N=16 and NET_W=10.
- R6: `net_vld` is high for exactly one cycle per word: the cycle after the edge that samples the word's bit P-1. In that cycle `net` holds the sum of all words completed since the clear.
- R7: In ST_IDLE (after reset, before any clear) `in_bit` has no effect and `net_vld` stays 0.
- R8: The controller moves from ST_IDLE to ST_FILL on `clr`, from ST_FILL to ST_ACC after the word's last bit, and from any state to ST_FILL on `clr`. Otherwise it holds its state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Start a new sum: zero chain, restart phase |
| in_bit | input | 1 | Serial product bit, LSB first |
| net | output | NET_W | Windowed net value for the activation stage |
| net_vld | output | 1 | One-cycle flag marking a word-aligned `net` |

## Verification
The assertions assume that `clr` is a single-cycle pulse. They also assume that product words follow the clear without gaps, so the bit phase inside the block always matches the producer's bit order. The stimulus respects this. It changes inputs only on falling edges. It starts every word on the cycle right after a clear or right after the previous word. It issues a clear only at a word boundary, except for one deliberate mid-word clear that checks the discard rule. The scoreboard then expects no valid pulse until a full word has arrived after that clear.

// File: rtl/sacc_pkg.sv
package sacc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_ACC  = 2'd2
    } sacc_state_e;

    function automatic int period_of(input int n);
        return 2 * n + 2;
    endfunction
endpackage

// File: rtl/sacc_phase.sv
module sacc_phase #(
    parameter int P  = 34,
    parameter int PW = $clog2(P)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [PW-1:0] phase,
    output logic          last
);
    localparam logic [PW-1:0] LAST_PH = PW'(P - 1);

    assign last = (phase == LAST_PH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (clr)
            phase <= '0;
        else if (en)
            phase <= last ? '0 : phase + 1'b1;
    end

    // R6: the phase counter never leaves its period
    p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST_PH);
endmodule

// File: rtl/sacc_adder.sv
module sacc_adder (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic word_start,
    input  logic a,
    input  logic b,
    output logic sum
);
    logic carry_q;
    logic cin;
    logic cout;

    always_comb begin
        cin  = word_start ? 1'b0 : carry_q;
        sum  = a ^ b ^ cin;
        cout = (a & b) | (cin & (a ^ b));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (clr || !en)
            carry_q <= 1'b0;
        else
            carry_q <= cout;
    end

    // R4: at bit 0 of a word the saved carry takes no part in the sum
    p_carry_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && word_start) |-> (sum == (a ^ b)));
endmodule

// File: rtl/sacc_chain.sv
module sacc_chain #(
    parameter int P = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [P-1:0] q
);
    genvar gi;
    generate
        for (gi = 0; gi < P; gi++) begin : g_stage
            logic nxt;
            if (gi == P - 1) begin : g_top
                assign nxt = din;
            end else begin : g_mid
                assign nxt = q[gi+1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[gi] <= 1'b0;
                else if (clr)
                    q[gi] <= 1'b0;
                else if (en)
                    q[gi] <= nxt;
            end
        end
    endgenerate

    // R2: a clear leaves an empty chain behind it
    p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
endmodule

// File: rtl/sacc_accum.sv
module sacc_accum
    import sacc_pkg::*;
#(
    parameter int N     = 16,
    parameter int NET_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_bit,
    output logic [NET_W-1:0] net,
    output logic             net_vld
);
    localparam int P       = period_of(N);
    localparam int PW      = $clog2(P);
    localparam int NET_LSB = 2 * N - NET_W - 2;

    sacc_state_e   st_q, st_d;
    logic          en;
    logic          ph_last;
    logic [PW-1:0] phase;
    logic          sum_bit;
    logic [P-1:0]  chain_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = ST_FILL;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_FILL: st_d = ph_last ? ST_ACC : ST_FILL;
                ST_ACC:  st_d = ST_ACC;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        en      = (st_q != ST_IDLE) && !clr;
        net_vld = (st_q == ST_ACC) && (phase == '0);
        net     = chain_q[NET_LSB +: NET_W];
    end

    sacc_phase #(.P(P), .PW(PW)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (en),
        .phase (phase),
        .last  (ph_last)
    );

    sacc_adder u_add (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .en         (en),
        .word_start (phase == '0),
        .a          (in_bit),
        .b          (chain_q[0]),
        .sum        (sum_bit)
    );

    sacc_chain #(.P(P)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (en),
        .din   (sum_bit),
        .q     (chain_q)
    );

    // R6: valid is a single-cycle pulse
    p_vld_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        net_vld |=> !net_vld);
    // R6: valid rises only right after the last bit of a word
    p_vld_after_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(net_vld) |-> $past(ph_last));
    // R7: idle never flags a net value
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !net_vld);
    // R8: clear always lands in the fill state
    p_fsm_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q == ST_FILL));
    // R8: idle is left only by a clear
    p_fsm_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !clr) |=> (st_q == ST_IDLE));
    // R8: fill hands over to accumulate at a word boundary
    p_fsm_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACC && $past(st_q) == ST_FILL) |-> (phase == '0));
endmodule

// File: tb/sacc_accum_test.sv
module sacc_accum_test;
    localparam int N     = 16;
    localparam int NET_W = 10;
    localparam int P     = 34;
    localparam int NL    = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             in_bit = 1'b0;
    logic [NET_W-1:0] net;
    logic             net_vld;

    int n_chk = 0;
    int n_fail = 0;
    logic [P-1:0]     acc;
    logic [NET_W-1:0] exp_q[$];
    string            req_q[$];

    always #2.5 clk = ~clk;

    sacc_accum #(.N(N), .NET_W(NET_W)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_bit(in_bit),
        .net(net), .net_vld(net_vld)
    );

    function automatic logic [NET_W-1:0] win(input logic [P-1:0] s);
        return s[NL +: NET_W];
    endfunction

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1;
        in_bit = 1'b1;
        acc = '0;
    endtask

    task automatic send_word(input logic [P-1:0] w, input string req);
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            clr = 1'b0;
            in_bit = w[i];
        end
        acc = acc + w;
        exp_q.push_back(win(acc));
        req_q.push_back(req);
    endtask

    task automatic send_bits(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            clr = 1'b0;
            in_bit = 1'b1;
        end
    endtask

    function automatic logic [P-1:0] prod(input int a, input int b);
        logic signed [P-1:0] pa;
        logic signed [P-1:0] pb;
        pa = P'(signed'(16'(a)));
        pb = P'(signed'(16'(b)));
        return pa * pb;
    endfunction

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && net_vld) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R6 R7: unexpected valid, net=%0d expected no valid", net);
                end else begin
                    logic [NET_W-1:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    if (net !== e) begin
                        n_fail++;
                        $display("FAIL %s: net=%0d expected %0d", r, net, e);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        acc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (net_vld !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: net_vld=%0b expected 0", net_vld);
        end
        n_chk++;
        if (net !== '0) begin
            n_fail++;
            $display("FAIL R1: net=%0d expected 0", net);
        end

        // R7: input toggled in idle, no valid must appear (monitor flags any)
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            in_bit = i[0];
        end
        n_chk++;
        if (net_vld !== 1'b0) begin
            n_fail++;
            $display("FAIL R7: net_vld=%0b expected 0", net_vld);
        end

        // R5: window position, one word at a time
        do_clr();
        send_word(P'(1) << NL, "R5");
        send_word(P'(1) << (NL + NET_W - 1), "R5");
        send_word((P'(1) << NL) - 1, "R5");
        send_word(P'(1) << (NL + NET_W), "R5");

        // R3: signed products summed modulo 2^P
        do_clr();
        for (int k = 0; k < 8; k++)
            send_word(prod(k * 4099 - 16000, 32767 - k * 5101), "R3");

        // R3: mixed-sign small values that land in the window
        do_clr();
        send_word(P'(3) << NL, "R3");
        send_word(-(P'(5) << NL), "R3");
        send_word(P'(2) << NL, "R3");

        // R4: carry out of the MSB must not leak into the next word
        do_clr();
        send_word('1, "R4");
        send_word('1, "R4");
        send_word('0, "R4");
        send_word(P'(1) << NL, "R4");

        // R2: clear in mid-word discards the partial sum
        do_clr();
        send_bits(P / 2);
        do_clr();
        send_word(P'(7) << NL, "R2");
        send_word(P'(9) << NL, "R2");

        // R8: clear from the accumulate state restarts filling
        do_clr();
        send_word(P'(11) << NL, "R8");

        repeat (5) @(negedge clk);
        // R6: every pushed word produced exactly one valid
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R6: %0d results missing, expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule